// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares one memory port per region among fourteen requesting clients by following a software-programmed schedule. Each region has its own table of 64 slots, and each slot names the client that owns it. A slot pointer moves through the table by one slot every clock cycle. The owner of the current slot is granted when it is requesting. When the owner is idle, another requester takes the slot, so no cycle is lost while any client is asking. There are two regions, external and internal. Their tables, pointers and grants are fully separate.

Software fills each table one slot at a time through a write port: an enable, a slot address and a client value. The grant path is combinational from the current pointer, the current table entry and the request vector, so a grant can be used in the same cycle as the request.

Each region decides its grant by one of three kinds: NONE when no client requests, OWNER when the slot owner requests, and FALLBACK when another requester takes the slot. The kind is re-evaluated every cycle from the current inputs, so any kind can follow any other.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: After reset each region's slot pointer is 0. It advances by one slot on every clock edge and wraps from slot 63 back to slot 0.
- R2: Reset contents: every internal table entry holds client 0. In the external table, even slots hold client 10 and odd slots hold client 11, so the two cache ports are scheduled from the start.
- R3: A write with the enable high replaces the entry addressed by the 6-bit slot number with the 4-bit client value at that clock edge. The new value decides the grant whenever the pointer reaches that slot, including the very next cycle. Other entries are unchanged.
- R4: When the current entry holds a client number from 0 to 13 and that client requests, only that client is granted (kind OWNER).
- R5: When the current entry holds a client number from 0 to 13 and that client is idle, the grant goes to the first requesting client in the order owner+1, owner+2, and so on, wrapping from 13 to 0 (kind FALLBACK).
- R6: Entry values 14 and 15 mean that no client owns the slot. Such a slot goes to the lowest-numbered requesting client.
- R7: With no request the grant vector is all zero (kind NONE). A grant vector never has more than one bit set and never grants a client that is not requesting.
- R8: The two regions are independent. Writes and requests for one region do not affect the grants of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbitration clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 14 | External-region request, bit n for client n |
| int_req | input | 14 | Internal-region request, bit n for client n |
| ext_wr_en | input | 1 | External table write enable |
| ext_wr_slot | input | 6 | External table slot address |
| ext_wr_client | input | 4 | External table entry value (14 and 15 mean unowned) |
| int_wr_en | input | 1 | Internal table write enable |
| int_wr_slot | input | 6 | Internal table slot address |
| int_wr_client | input | 4 | Internal table entry value (14 and 15 mean unowned) |
| ext_gnt | output | 14 | External-region one-hot grant |
| int_gnt | output | 14 | Internal-region one-hot grant |

## Verification
With all requests high, the grant sequence copies the table entries in slot order. This exposes pointer stepping, wrap and reset contents, and keeps fallback out of the picture. A walking single request, applied while the tables hold every value from 0 to 15, separates owner grants, forward wrap-around search and the unowned-slot rule. Quiet cycles with no request show that nothing is granted. Sparse pseudo-random requests across many table rotations mix all three grant kinds. During table programming, each write targets the slot the pointer reaches next, which shows the new value governs at once. Writes go to one region at a time, which shows the other region is untouched.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    // How a region decided its grant in the current cycle.
    typedef enum logic [1:0] {
        GK_NONE     = 2'd0,
        GK_OWNER    = 2'd1,
        GK_FALLBACK = 2'd2
    } gnt_kind_e;

endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter int N_SLOTS  = 64,
    parameter int IDX_W    = 4,
    parameter int RST_EVEN = 0,
    parameter int RST_ODD  = 0,
    localparam int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_val,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_val
);

    logic [IDX_W-1:0] entry_q [N_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                entry_q[s] <= (s % 2 == 0) ? IDX_W'(RST_EVEN) : IDX_W'(RST_ODD);
            end
        end else if (wr_en) begin
            entry_q[wr_slot] <= wr_val;
        end
    end

    assign rd_val = entry_q[rd_slot];

endmodule

// File: rtl/tdm_grant_pick.sv
module tdm_grant_pick
    import tdm_arb_pkg::*;
#(
    parameter int N_CLIENTS = 14,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0]     owner,
    input  logic [N_CLIENTS-1:0] req,
    output logic [N_CLIENTS-1:0] gnt,
    output gnt_kind_e            kind
);

    localparam int CW = IDX_W + 1;

    logic             owner_ok;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] win;
    logic             found;
    logic [CW-1:0]    cand;

    // Search starts at the owner (or at client 0 for an unowned slot)
    // and walks forward with wrap until a requester is met.
    always_comb begin
        owner_ok = (int'(owner) < N_CLIENTS);
        base     = owner_ok ? owner : '0;
        found    = 1'b0;
        win      = '0;
        cand     = '0;
        for (int k = 0; k < N_CLIENTS; k++) begin
            cand = {1'b0, base} + CW'(k);
            if (cand >= CW'(N_CLIENTS)) begin
                cand = cand - CW'(N_CLIENTS);
            end
            if (!found && req[cand[IDX_W-1:0]]) begin
                found = 1'b1;
                win   = cand[IDX_W-1:0];
            end
        end
        if (!found) begin
            kind = GK_NONE;
        end else if (owner_ok && win == owner) begin
            kind = GK_OWNER;
        end else begin
            kind = GK_FALLBACK;
        end
    end

    always_comb begin
        gnt = '0;
        unique case (kind)
            GK_NONE:               gnt = '0;
            GK_OWNER, GK_FALLBACK: gnt[win] = 1'b1;
            default:               gnt = '0;
        endcase
    end

endmodule

// File: rtl/tdm_region.sv
module tdm_region
    import tdm_arb_pkg::*;
#(
    parameter int N_CLIENTS = 14,
    parameter int N_SLOTS   = 64,
    parameter int RST_EVEN  = 0,
    parameter int RST_ODD   = 0,
    localparam int IDX_W    = $clog2(N_CLIENTS + 1),
    localparam int SLOT_W   = $clog2(N_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] req,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [IDX_W-1:0]     wr_val,
    output logic [N_CLIENTS-1:0] gnt
);

    logic [SLOT_W-1:0] ptr_q;
    logic [IDX_W-1:0]  owner;
    gnt_kind_e         kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_q == SLOT_W'(N_SLOTS - 1)) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    tdm_slot_table #(
        .N_SLOTS (N_SLOTS),
        .IDX_W   (IDX_W),
        .RST_EVEN(RST_EVEN),
        .RST_ODD (RST_ODD)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_slot(wr_slot),
        .wr_val (wr_val),
        .rd_slot(ptr_q),
        .rd_val (owner)
    );

    tdm_grant_pick #(
        .N_CLIENTS(N_CLIENTS),
        .IDX_W    (IDX_W)
    ) pick_i (
        .owner(owner),
        .req  (req),
        .gnt  (gnt),
        .kind (kind)
    );

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ptr_q == (($past(ptr_q) == SLOT_W'(N_SLOTS - 1)) ? '0 : $past(ptr_q) + 1'b1)); // R1
    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R7
    AST_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R7
    AST_NO_WASTE: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt)); // R5
    AST_OWNER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(owner) < N_CLIENTS && req[owner]) |-> gnt[owner]); // R4
    AST_KIND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == GK_NONE) == (gnt == '0)); // R7

endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
    parameter int N_CLIENTS    = 14,
    parameter int N_SLOTS      = 64,
    parameter int EXT_RST_EVEN = 10,
    parameter int EXT_RST_ODD  = 11,
    parameter int INT_RST      = 0,
    localparam int IDX_W       = $clog2(N_CLIENTS + 1),
    localparam int SLOT_W      = $clog2(N_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] ext_req,
    input  logic [N_CLIENTS-1:0] int_req,
    input  logic                 ext_wr_en,
    input  logic [SLOT_W-1:0]    ext_wr_slot,
    input  logic [IDX_W-1:0]     ext_wr_client,
    input  logic                 int_wr_en,
    input  logic [SLOT_W-1:0]    int_wr_slot,
    input  logic [IDX_W-1:0]     int_wr_client,
    output logic [N_CLIENTS-1:0] ext_gnt,
    output logic [N_CLIENTS-1:0] int_gnt
);

    localparam int N_REGIONS = 2;

    logic [N_CLIENTS-1:0] req_a  [N_REGIONS];
    logic [N_CLIENTS-1:0] gnt_a  [N_REGIONS];
    logic                 we_a   [N_REGIONS];
    logic [SLOT_W-1:0]    slot_a [N_REGIONS];
    logic [IDX_W-1:0]     val_a  [N_REGIONS];

    assign req_a[0]  = ext_req;
    assign req_a[1]  = int_req;
    assign we_a[0]   = ext_wr_en;
    assign we_a[1]   = int_wr_en;
    assign slot_a[0] = ext_wr_slot;
    assign slot_a[1] = int_wr_slot;
    assign val_a[0]  = ext_wr_client;
    assign val_a[1]  = int_wr_client;
    assign ext_gnt   = gnt_a[0];
    assign int_gnt   = gnt_a[1];

    for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
        localparam int RE = (r == 0) ? EXT_RST_EVEN : INT_RST;
        localparam int RO = (r == 0) ? EXT_RST_ODD  : INT_RST;
        tdm_region #(
            .N_CLIENTS(N_CLIENTS),
            .N_SLOTS  (N_SLOTS),
            .RST_EVEN (RE),
            .RST_ODD  (RO)
        ) region_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_a[r]),
            .wr_en  (we_a[r]),
            .wr_slot(slot_a[r]),
            .wr_val (val_a[r]),
            .gnt    (gnt_a[r])
        );
    end

endmodule

// File: tb/tdm_slot_arbiter_tb_top.sv
module tdm_slot_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ext_req = '0, int_req = '0;
    logic        ext_wr_en = 1'b0, int_wr_en = 1'b0;
    logic [5:0]  ext_wr_slot = '0, int_wr_slot = '0;
    logic [3:0]  ext_wr_client = '0, int_wr_client = '0;
    logic [13:0] ext_gnt, int_gnt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ext_m [64];
    int int_m [64];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    tdm_slot_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .ext_req(ext_req), .int_req(int_req),
        .ext_wr_en(ext_wr_en), .ext_wr_slot(ext_wr_slot), .ext_wr_client(ext_wr_client),
        .int_wr_en(int_wr_en), .int_wr_slot(int_wr_slot), .int_wr_client(int_wr_client),
        .ext_gnt(ext_gnt), .int_gnt(int_gnt)
    );

    function automatic logic [13:0] expect_gnt(input int o, input logic [13:0] r);
        if (r == 0) return '0;
        if (o < 14) begin
            for (int d = 0; d < 14; d++) if (r[(o + d) % 14]) return 14'(1) << ((o + d) % 14);
        end else begin
            for (int c = 0; c < 14; c++) if (r[c]) return 14'(1) << c;
        end
        return '0;
    endfunction

    function automatic string auto_tag(input int o, input logic [13:0] r);
        if (r == 0) return "R7";
        if (o >= 14) return "R6";
        if (r[o]) return "R4";
        return "R5";
    endfunction

    task automatic check_one(input string region, input logic [13:0] act, input int o,
                             input logic [13:0] r, input string tag);
        logic [13:0] exp;
        string t;
        exp = expect_gnt(o, r);
        t = (tag == "") ? auto_tag(o, r) : tag;
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s slot=%0d owner=%0d req=%h actual=%h expected=%h",
                     t, region, cyc, o, r, act, exp);
        end
    endtask

    // Called just after a falling edge; checks, then crosses one rising edge.
    task automatic step(input logic [13:0] er, input logic [13:0] ir,
                        input bit ewe, input int es, input int ec,
                        input bit iwe, input int is_, input int ic,
                        input string etag, input string itag);
        ext_req = er; int_req = ir;
        ext_wr_en = ewe; ext_wr_slot = es[5:0]; ext_wr_client = ec[3:0];
        int_wr_en = iwe; int_wr_slot = is_[5:0]; int_wr_client = ic[3:0];
        #1;
        check_one("ext", ext_gnt, ext_m[cyc], er, etag);
        check_one("int", int_gnt, int_m[cyc], ir, itag);
        @(posedge clk);
        if (ewe) ext_m[es] = ec;
        if (iwe) int_m[is_] = ic;
        cyc = (cyc + 1) % 64;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired at slot=%0d actual=running expected=done", cyc);
        finish_run();
    end

    function automatic logic [13:0] sparse();
        return lfsr[13:0] & {lfsr[6:0], lfsr[13:7]};
    endfunction

    initial begin
        for (int s = 0; s < 64; s++) begin
            ext_m[s] = (s % 2 == 0) ? 10 : 11;  // R2 reset contents
            int_m[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;

        // R2 / R1: reset contents and pointer stepping seen with everyone requesting
        for (int i = 0; i < 66; i++) step('1, '1, 0, 0, 0, 0, 0, 0, "R2", "R2");

        // R3: program external table, each write aimed at the next slot; R8 internal unaffected
        for (int i = 0; i < 64; i++)
            step(sparse(), '1, 1, (cyc + 1) % 64, ((cyc + 1) * 5 + 3) % 16,
                 0, 0, 0, "R3", "R8");
        // R3: program internal table the same way; R8 external unaffected
        for (int i = 0; i < 64; i++)
            step('1, sparse(), 0, 0, 0, 1, (cyc + 1) % 64, ((cyc + 1) * 7) % 16,
                 "R8", "R3");

        // R1: full rotation with all requesting follows the table in slot order
        for (int i = 0; i < 70; i++) step('1, '1, 0, 0, 0, 0, 0, 0, "R1", "R1");
        // R4/R5/R6: walking single requester
        for (int i = 0; i < 14 * 16; i++)
            step(14'(1) << (i % 14), 14'(1) << ((i / 3) % 14), 0, 0, 0, 0, 0, 0, "", "");
        // R7: nobody requests
        for (int i = 0; i < 64; i++) step('0, '0, 0, 0, 0, 0, 0, 0, "R7", "R7");
        // mixed sparse traffic with automatic tagging
        for (int i = 0; i < 512; i++)
            step(sparse(), ~lfsr[13:0] & {lfsr[3:0], lfsr[13:4]}, 0, 0, 0, 0, 0, 0, "", "");
        // R3: rewrite a single slot with unowned code while running
        for (int i = 0; i < 64; i++)
            step(lfsr[13:0], lfsr[13:0], (i % 8) == 0, (cyc + 1) % 64, 15,
                 (i % 8) == 4, (cyc + 1) % 64, 14, "", "");

        finish_run();
    end

endmodule